// File: doc/BRIEF.md
# Rate-Programmable Bit Error Injector

This block sits in a serial transmit path between a pattern source and the line driver and corrupts chosen bits on purpose. A link under test can then be checked for detection of known error rates. Each bit is qualified by a clock enable. A 3-bit rate code selects automatic corruption at one decade rate between one error in ten bits and one error in ten million bits. A strobe injects a single error on demand, so software can set rates slower than any code provides. A separate control inverts the whole outgoing stream.

Corruption flips the bit as it leaves the block. The rate is counted by a chain of decade digits, one digit for each power of ten. The data path holds exactly one register, and its output is held steady on cycles where the enable is low.

Top module: `bit_err_injector`

## Requirements
- R1: With rate code 0, no bit is corrupted automatically.
- R2: With rate code n (1 to 7), automatic corruption flips every 10^n-th enabled bit. Counting starts at reset or at the last code change, so the first flip lands on the 10^n-th enabled bit.
- R3: A change of the rate code between one cycle and the next clears the interval count. The cycle that carries the new code is neither counted nor corrupted.
- R4: A low-to-high transition of `single_err` flips exactly one bit: the bit on that cycle if `bit_en` is 1, or else the next enabled bit.
- R5: Holding `single_err` at 1 causes no further flips. It must return to 0 before another single error can be requested.
- R6: When a single error and an automatic error fall on the same bit, that bit is flipped once. It is not flipped twice.
- R7: With `tx_invert` at 1, every output bit is the complement of the bit after corruption. With `tx_invert` at 0, bits pass through unchanged apart from corruption.
- R8: `dout` shows the bit presented on the previous enabled cycle. It holds its value while `bit_en` is 0.
- R9: During reset `dout` is 0, and both the interval count and any pending single error are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks a cycle that carries a serial bit |
| din | input | 1 | Serial transmit bit in |
| rate_code | input | 3 | 0 = automatic insertion off; n = one error every 10^n bits |
| single_err | input | 1 | Rising edge requests one corrupted bit |
| tx_invert | input | 1 | 1 = complement every output bit |
| dout | output | 1 | Serial transmit bit out, one register stage late |

## Verification
Each output bit is due one clock after the enabled cycle that carries its input. The bench drives inputs on the falling edge. It compares `dout` on the following falling edge against a reference model that stepped the same inputs in the previous step, so every comparison lands exactly one register later. Automatic errors are due on the 10^n-th enabled bit after reset or after a code change. Single errors are due on the first enabled bit at or after the strobe's rising edge. The model counts both in enabled bits and not in cycles, so stretches with `bit_en` low shift the expected flips by exactly the idle cycles.

// File: rtl/bei_pkg.sv
package bei_pkg;
   localparam int CODE_W  = 3;
   localparam int DIGIT_W = 4;
   localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;
   typedef logic [DIGIT_W-1:0] digit_t;
   typedef logic [CODE_W-1:0]  code_t;
endpackage

// File: rtl/bei_decade_digit.sv
module bei_decade_digit
   import bei_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clr,
   input  logic   inc,
   output digit_t digit,
   output logic   carry
);
   digit_t digit_q;

   assign digit = digit_q;
   assign carry = inc && (digit_q == DIGIT_TOP);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)   digit_q <= '0;
      else if (carry)      digit_q <= '0;
      else if (inc)        digit_q <= digit_q + 1'b1;
   end

   a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      digit_q <= DIGIT_TOP)
      else $error("decade digit left range");
endmodule

// File: rtl/bei_interval.sv
module bei_interval
   import bei_pkg::*;
#(
   parameter int NUM_DECADES = 7
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bit_en,
   input  code_t rate_code,
   output logic  auto_hit
);
   localparam int MAX_CODE = (1 << CODE_W) - 1;

   if (NUM_DECADES < 1 || NUM_DECADES > MAX_CODE) begin : g_bad_cfg
      $error("NUM_DECADES must lie between 1 and the largest rate code");
   end

   code_t code_q;
   logic  changed, active, inc0, clear, hit_sel, any_nonzero;
   logic  [NUM_DECADES-1:0] inc, carry;
   digit_t digits [NUM_DECADES];

   always_ff @(posedge clk) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= rate_code;
   end

   assign changed = (rate_code != code_q);
   assign active  = (rate_code != '0) && (int'(rate_code) <= NUM_DECADES);
   assign inc0    = bit_en && active && !changed;

   for (genvar i = 0; i < NUM_DECADES; i++) begin : g_chain
      if (i == 0) begin : g_first
         assign inc[i] = inc0;
      end else begin : g_next
         assign inc[i] = carry[i-1];
      end
      bei_decade_digit u_digit (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clear),
         .inc   (inc[i]),
         .digit (digits[i]),
         .carry (carry[i])
      );
   end

   always_comb begin
      hit_sel = 1'b0;
      for (int k = 0; k < NUM_DECADES; k++)
         if (int'(rate_code) == k + 1) hit_sel = carry[k];
   end

   always_comb begin
      any_nonzero = 1'b0;
      for (int k = 0; k < NUM_DECADES; k++)
         if (digits[k] != '0) any_nonzero = 1'b1;
   end

   assign auto_hit = hit_sel;
   assign clear    = changed || hit_sel;

   a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_code == '0) |-> !auto_hit)
      else $error("automatic error with insertion off");

   a_r3_code_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
      changed |=> !any_nonzero)
      else $error("interval count survived a code change");
endmodule

// File: rtl/bei_single.sv
module bei_single (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic single_err,
   output logic single_hit
);
   logic strobe_q, pend_q, rise;

   assign rise       = single_err && !strobe_q;
   assign single_hit = bit_en && (pend_q || rise);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         strobe_q <= single_err;
         pend_q   <= (pend_q || rise) && !bit_en;
      end
   end

   a_r4_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      single_hit |=> !pend_q)
      else $error("single error still pending after use");

   a_r5_level_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_q && single_err && !pend_q) |-> !single_hit)
      else $error("held strobe produced another error");
endmodule

// File: rtl/bit_err_injector.sv
module bit_err_injector
   import bei_pkg::*;
#(
   parameter int NUM_DECADES = 7
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       din,
   input  logic [2:0] rate_code,
   input  logic       single_err,
   input  logic       tx_invert,
   output logic       dout
);
   if (CODE_W != 3) begin : g_bad_width
      $error("rate code port assumes a 3-bit code");
   end

   logic auto_hit, single_hit, flip, dout_q;

   bei_interval #(.NUM_DECADES(NUM_DECADES)) u_interval (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .rate_code (rate_code),
      .auto_hit  (auto_hit)
   );

   bei_single u_single (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .single_err (single_err),
      .single_hit (single_hit)
   );

   assign flip = auto_hit || single_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)      dout_q <= 1'b0;
      else if (bit_en) dout_q <= (din ^ flip) ^ tx_invert;
   end

   assign dout = dout_q;

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(dout))
      else $error("output moved without enable");

   a_r6_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && auto_hit && single_hit) |=> (dout == !($past(din) ^ $past(tx_invert))))
      else $error("coincident errors did not flip exactly once");

   a_r7_invert: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && tx_invert && !auto_hit && !single_hit) |=> (dout != $past(din)))
      else $error("inversion not applied");
endmodule

// File: tb/sim_bit_err_injector.sv
module sim_bit_err_injector;
   localparam int CLK_P = 10;
   localparam int WATCHDOG = 195000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, din = 1'b0, single_err = 1'b0, tx_invert = 1'b0;
   logic [2:0] rate_code = 3'd0;
   logic dout;

   int n_checks = 0;
   int n_fail   = 0;
   string req   = "R9";

   // reference model state
   logic [2:0] m_code_q = 3'd0;
   int   m_cnt    = 0;
   logic m_se_q   = 1'b0;
   logic m_pend   = 1'b0;
   logic exp_dout = 1'b0;
   bit   done     = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bit_err_injector u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din),
      .rate_code(rate_code), .single_err(single_err),
      .tx_invert(tx_invert), .dout(dout)
   );

   function automatic int pow10(input int n);
      int r = 1;
      for (int i = 0; i < n; i++) r = r * 10;
      return r;
   endfunction

   task automatic check(input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: dout=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // compare the result of the previous step, then apply new inputs
   task automatic step(input logic en, input logic d, input logic [2:0] code,
                       input logic se, input logic inv);
      logic changed, rise, auto_e, single_e;
      @(negedge clk);
      check(dout, exp_dout);
      bit_en = en; din = d; rate_code = code; single_err = se; tx_invert = inv;
      changed = (code != m_code_q);
      auto_e  = 1'b0;
      if (changed) m_cnt = 0;
      else if (en && code != 3'd0) begin
         if (m_cnt == pow10(int'(code)) - 1) begin auto_e = 1'b1; m_cnt = 0; end
         else m_cnt++;
      end
      m_code_q = code;
      rise     = se && !m_se_q;
      m_se_q   = se;
      single_e = en && (m_pend || rise);
      m_pend   = (m_pend || rise) && !en;
      if (en) exp_dout = d ^ (auto_e || single_e) ^ inv;
   endtask

   task automatic rnd_run(input int cycles, input logic [2:0] code, input int en_pct,
                          input logic inv);
      for (int i = 0; i < cycles; i++)
         step(($urandom % 100) < en_pct, $urandom % 2, code, 1'b0, inv);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // R9: reset state, even with inputs wiggling
      bit_en = 1'b1; din = 1'b1; tx_invert = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      req = "R9"; check(dout, 1'b0);
      bit_en = 1'b0; din = 1'b0; tx_invert = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R1 and R7 pass-through: code 0, no inversion
      req = "R1"; rnd_run(300, 3'd0, 70, 1'b0);
      // R8: sparse enable, output must hold between bits
      req = "R8"; rnd_run(400, 3'd0, 20, 1'b0);

      // R2: each testable decade rate
      req = "R2"; rnd_run(500, 3'd1, 75, 1'b0);
      rnd_run(1200, 3'd2, 85, 1'b0);
      rnd_run(3000, 3'd3, 100, 1'b0);
      rnd_run(25000, 3'd4, 100, 1'b0);
      rnd_run(101000, 3'd5, 100, 1'b0);
      rnd_run(2000, 3'd7, 100, 1'b0);

      // R3: code hopping, including changes on idle cycles
      req = "R3";
      for (int b = 0; b < 60; b++) begin
         logic [2:0] c = ($urandom % 2) ? 3'd1 : 3'd2;
         rnd_run(5 + ($urandom % 40), c, 80, 1'b0);
      end
      step(1'b1, 1'b0, 3'd1, 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'd1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 3'd2, 1'b0, 1'b0);   // change: this bit not counted
      for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 3'd2, 1'b0, 1'b0);

      // R4: single pulses with enable high
      req = "R4"; rnd_run(10, 3'd0, 100, 1'b0);
      for (int p = 0; p < 20; p++) begin
         step(1'b1, $urandom % 2, 3'd0, 1'b1, 1'b0);
         step(1'b1, $urandom % 2, 3'd0, 1'b0, 1'b0);
         rnd_run(3, 3'd0, 100, 1'b0);
      end
      // R4: rising edge on an idle cycle lands on the next enabled bit
      for (int p = 0; p < 10; p++) begin
         step(1'b0, 1'b0, 3'd0, 1'b1, 1'b0);
         step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
         step(1'b0, 1'b1, 3'd0, 1'b0, 1'b0);
         step(1'b1, 1'b1, 3'd0, 1'b0, 1'b0);
         step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0);
      end
      // R5: strobe held high flips only once
      req = "R5";
      for (int i = 0; i < 30; i++) step(1'b1, $urandom % 2, 3'd0, 1'b1, 1'b0);
      step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0);
      for (int i = 0; i < 400; i++)
         step(($urandom % 100) < 70, $urandom % 2, 3'd0, ($urandom % 8) == 0, 1'b0);

      // R6: strobe timed onto the 10th bit at code 1
      req = "R6"; rnd_run(3, 3'd1, 100, 1'b0);
      for (int r = 0; r < 15; r++) begin
         while (m_cnt != 9) step(1'b1, $urandom % 2, 3'd1, 1'b0, 1'b0);
         step(1'b1, $urandom % 2, 3'd1, 1'b1, 1'b0);
         step(1'b1, $urandom % 2, 3'd1, 1'b0, 1'b0);
      end

      // R7: inverted stream with automatic and single errors
      req = "R7"; rnd_run(500, 3'd1, 80, 1'b1);
      for (int i = 0; i < 300; i++)
         step(($urandom % 100) < 80, $urandom % 2, 3'd2, ($urandom % 6) == 0, 1'b1);
      rnd_run(200, 3'd0, 90, 1'b1);

      req = "R8"; step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule